// File: doc/BRIEF.md
# ALU Control Decoder

This block turns a two-bit operation class from the main instruction decoder and the six-bit function field of a register-format instruction into the four-bit select that steers the ALU in a single-cycle processor. Memory-access instructions need an address sum. Equality branches need a difference so that the zero flag can be tested. Register-format instructions name their arithmetic or logic operation in the function field.

The decode runs in two levels. The first level classifies the operation-class code and tests each bit only where it is needed. The second level decodes the low nibble of the function field. The block is purely combinational: the select follows its inputs in the same time step, with no clock, no storage and no latch.

Top module: `alu_ctl_decoder`

## Requirements
- R1: With op_class = 2'b00 (memory access), alu_sel is 4'b0010 (add) for every one of the 64 func_field values.
- R2: With op_class = 2'b01 (equality branch), alu_sel is 4'b0110 (subtract) for every func_field value.
- R3: Bit 0 of op_class is ignored when bit 1 is set, so op_class = 2'b11 gives the same alu_sel as 2'b10 for every func_field value.
- R4: With op_class[1] = 1, func_field[3:0] selects the operation: 4'b0000 gives add (4'b0010), 4'b0010 gives subtract (4'b0110), 4'b0100 gives AND (4'b0000), 4'b0101 gives OR (4'b0001), and 4'b1010 gives set-less-than (4'b0111).
- R5: With op_class[1] = 1, func_field[5:4] has no effect on alu_sel.
- R6: With op_class[1] = 1, any func_field[3:0] value not listed in R4 gives add (4'b0010).
- R7: alu_sel is always one of the five codes AND, OR, add, subtract or set-less-than. It has no unknown bit when the inputs are known, and it settles in the same time step as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder: 00 memory, 01 branch, 1x register format |
| func_field | input | 6 | Function field of the instruction word |
| alu_sel | output | 4 | ALU operation select |

## Verification
The block holds no state, so a wrong internal decision can only show up as a wrong select in the same time step as the input pattern that triggers it. An error in the class stage, such as testing the wrong bit of op_class, corrupts whole groups of 64 function codes. An error in the function stage shows up on single nibble values, or on codes that differ only in their upper two bits. All 256 input combinations are therefore applied and compared one by one, so that every class pattern, every listed function code, every unlisted code and every don't-care bit is covered.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

    localparam int CLASS_W = 2;
    localparam int FUNC_W  = 6;
    localparam int SEL_W   = 4;
    localparam int NIB_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111
    } alu_sel_e;

    typedef enum logic [1:0] {
        KIND_MEM   = 2'd0,
        KIND_BRANCH = 2'd1,
        KIND_REG   = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        alu_sel_e fixed_sel;
    } class_res_t;

    // Low-nibble function codes used by the register-format decode
    localparam logic [NIB_W-1:0] NIB_ADD = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_SUB = 4'b0010;
    localparam logic [NIB_W-1:0] NIB_AND = 4'b0100;
    localparam logic [NIB_W-1:0] NIB_OR  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_SLT = 4'b1010;

    function automatic alu_sel_e nib_to_sel(input logic [NIB_W-1:0] nib);
        alu_sel_e s;
        case (nib)
            NIB_ADD: s = SEL_ADD;
            NIB_SUB: s = SEL_SUB;
            NIB_AND: s = SEL_AND;
            NIB_OR:  s = SEL_OR;
            NIB_SLT: s = SEL_SLT;
            default: s = SEL_ADD;   // R6: unlisted code falls back to add
        endcase
        return s;
    endfunction

endpackage

// File: rtl/alu_ctl_class.sv
module alu_ctl_class
    import alu_ctl_pkg::*;
#(
    parameter int CW = CLASS_W
) (
    input  logic [CW-1:0] op_class,
    output class_res_t    res
);
    // First level: bit 1 alone marks register format (R3), otherwise bit 0
    // alone marks a branch; code 11 is claimed by register format.
    always_comb begin
        res = '{kind: KIND_MEM, fixed_sel: SEL_ADD};           // R1
        if (op_class[CW-1]) begin
            res = '{kind: KIND_REG, fixed_sel: SEL_ADD};
        end else if (op_class[0]) begin
            res = '{kind: KIND_BRANCH, fixed_sel: SEL_SUB};    // R2
        end
    end
endmodule

// File: rtl/alu_ctl_func.sv
module alu_ctl_func
    import alu_ctl_pkg::*;
#(
    parameter int FW = FUNC_W,
    parameter int NW = NIB_W
) (
    input  logic [FW-1:0] func_field,
    output alu_sel_e      func_sel
);
    logic [NW-1:0] nib;

    // Second level: only the low nibble is decoded, upper bits dropped (R5)
    assign nib      = func_field[NW-1:0];
    assign func_sel = nib_to_sel(nib);                           // R4
endmodule

// File: rtl/alu_ctl_decoder.sv
module alu_ctl_decoder
    import alu_ctl_pkg::*;
#(
    parameter int CW = CLASS_W,
    parameter int FW = FUNC_W,
    parameter int SW = SEL_W
) (
    input  logic [CW-1:0] op_class,
    input  logic [FW-1:0] func_field,
    output logic [SW-1:0] alu_sel
);
    class_res_t cls;
    alu_sel_e   fsel;

    alu_ctl_class #(.CW(CW)) class_i (
        .op_class (op_class),
        .res      (cls)
    );

    alu_ctl_func #(.FW(FW), .NW(NIB_W)) func_i (
        .func_field (func_field),
        .func_sel   (fsel)
    );

    // Fully assigned select: no storage, no latch (R7)
    always_comb begin
        if (cls.kind == KIND_REG) alu_sel = fsel;
        else                      alu_sel = cls.fixed_sel;
    end
endmodule

// File: rtl/alu_ctl_checker.sv
module alu_ctl_checker
    import alu_ctl_pkg::*;
(
    input logic [CLASS_W-1:0] op_class,
    input logic [FUNC_W-1:0]  func_field,
    input logic [SEL_W-1:0]   alu_sel
);
    always_comb begin
        if (!$isunknown({op_class, func_field})) begin
            AST_MEM_IS_ADD: assert (op_class != 2'b00 || alu_sel == 4'b0010); // R1
            AST_BRANCH_IS_SUB: assert (op_class != 2'b01 || alu_sel == 4'b0110); // R2
            AST_REG_SLT_CODE: assert (!(op_class[1] && func_field[3:0] == 4'b1010) || alu_sel == 4'b0111); // R4
            AST_REG_DEFAULT_ADD: assert (!(op_class[1] && !(func_field[3:0] inside {4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010})) || alu_sel == 4'b0010); // R6
            AST_SEL_LEGAL: assert (!$isunknown(alu_sel) && (alu_sel inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111})); // R7
        end
    end
endmodule

bind alu_ctl_decoder alu_ctl_checker chk_i (
    .op_class   (op_class),
    .func_field (func_field),
    .alu_sel    (alu_sel)
);

// File: tb/alu_ctl_decoder_tb_top.sv
module alu_ctl_decoder_tb_top;

    typedef struct {
        logic [1:0] cls;
        logic [5:0] fn;
        logic [3:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_class = 2'b00;
    logic [5:0] func_field = 6'd0;
    logic [3:0] alu_sel;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    alu_ctl_decoder dut_i (
        .op_class   (op_class),
        .func_field (func_field),
        .alu_sel    (alu_sel)
    );

    // Expected select written from the requirements
    function automatic logic [3:0] model(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 4'b0010;          // R1
        if (c == 2'b01) return 4'b0110;          // R2
        case (f[3:0])                            // R3 R4 R5
            4'b0000: return 4'b0010;
            4'b0010: return 4'b0110;
            4'b0100: return 4'b0000;
            4'b0101: return 4'b0001;
            4'b1010: return 4'b0111;
            default: return 4'b0010;             // R6
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
        bit listed;
        listed = f[3:0] inside {4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010};
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        if (c == 2'b11) return "R3";
        if (!listed)    return "R6";
        if (f[5:4] != 2'b00) return "R5";
        return "R4";
    endfunction

    task automatic drive(input logic [1:0] c, input logic [5:0] f);
        item_t it;
        @(posedge clk);
        #1;
        op_class   = c;
        func_field = f;
        it.cls = c;
        it.fn  = f;
        it.exp = model(c, f);
        it.req = req_of(c, f);
        sb_q.push_back(it);
    endtask

    // Monitor: compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (alu_sel !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s class=%b func=%b actual=%b expected=%b",
                             it.req, it.cls, it.fn, alu_sel, it.exp);
                end
                n_checks++;
                if ($isunknown(alu_sel)) begin
                    n_fail++;
                    $display("FAIL R7 class=%b func=%b actual=%b expected=known",
                             it.cls, it.fn, alu_sel);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time state: idle inputs give the add code
        @(negedge clk);
        n_checks++;
        if (alu_sel !== 4'b0010) begin
            n_fail++;
            $display("FAIL R1 reset-state actual=%b expected=0010", alu_sel);
        end
        // Listed codes first, then the exhaustive sweep over all patterns
        drive(2'b10, 6'b100000);
        drive(2'b10, 6'b100010);
        drive(2'b10, 6'b100100);
        drive(2'b10, 6'b100101);
        drive(2'b10, 6'b101010);
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                drive(c[1:0], f[5:0]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule